// File: doc/BRIEF.md
# Cellular Automaton Row Generator

This block draws a one-dimensional, binary, nearest-neighbour cellular automaton into a shared frame buffer. Each buffer row holds one generation, so time runs down the screen. After a start command it writes a seed row at row 0. It then fills rows 1 to the last generation row one cell at a time. For each target cell it reads three cells of the row above, builds a 3-bit neighbourhood code, looks that code up in an 8-bit rule and writes the resulting pixel. When the last row is done it idles. A scroll command copies the final row into row 0 and grows a fresh screen from it.

The frame buffer is shared with a display engine and may be used only while the external grant is high, which is normally during blanking. If the grant drops at any point during the reads or the write of a cell, the cell's partial work is discarded. The whole cell is then redone, starting again from its first neighbour read. Pixels are 16-bit words. Only the top bit says whether a cell is alive; the other bits carry colour from a built-in pseudo-random generator.

Top module: `ca_row_gen`

## Requirements
- R1: For the cell at (row y, column x), the block reads row y-1 at columns x-1, x and x+1, in that order. It forms code = 4*left + 2*centre + right and makes the cell live exactly when rule[code] is 1. A live word has bit 15 = 1 and bits 14, 9 and 4 = 1. A dead word is 16'h0000.
- R2: A stored word counts as alive only through bit 15. A word with bit 15 = 0 counts as dead, whatever its other bits are.
- R3: A neighbour outside columns 0..LAST_COL reads as dead, and the block issues no memory read to any column above LAST_COL.
- R4: A start with seed_rand = 0 writes row 0 so that column (LAST_COL+1)/2 holds 16'hFFFF and every other column 0..LAST_COL holds 16'h0000.
- R5: A start with seed_rand = 1 takes each row-0 column from a 31-bit generator g, which resets to 31'h55555555 and steps to {g[29:0], g[27]^g[30]}. The column is live when g[30] = 1, and a live word is {1, 1, g[17:14], 1, g[10:7], 1, g[3:0]}. Columns are filled from 0 upward.
- R6: No memory request is issued while grant is low.
- R7: Grant loss during a cell causes that cell to be recomputed. Each cell of a generation pass is written exactly once.
- R8: Writes go through columns 0..LAST_COL of row 0, then of row 1, and so on up to LAST_ROW. After that the block enters idle.
- R9: In idle the idle output is high and no memory request is made. Idle lasts until start or scroll.
- R10: Scroll in idle copies each word of row LAST_ROW into row 0, column by column, unchanged. It then regenerates rows 1..LAST_ROW from the copied row.
- R11: After reset the block is not idle and makes no memory request until start.
- R12: The generator steps once per randomly seeded column and once per live cell written by the rule. Its state carries over from one pass to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new screen from a seed (taken in init or idle) |
| seed_rand | input | 1 | Seed choice sampled with start: 0 centre cell, 1 random row |
| scroll | input | 1 | In idle, copy the last row to the top and continue |
| rule | input | 8 | Rule vector, bit n gives the result for neighbourhood code n |
| grant | input | 1 | Frame-buffer access permitted |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | $clog2(COLS*ROWS) | Word address, row*COLS + column |
| mem_wdata | output | 16 | Write data |
| idle | output | 1 | Screen finished, waiting for a command |

## Verification
A memory access shows up at the bench memory on the rising edge after mem_req is seen high. Read data is returned on that same edge, so the block captures it one cycle later. The order and count of writes are therefore checked as they occur at the memory, while the frame contents are compared only after idle rises. That is one cycle after the last write, and the comparison is made at the next falling edge. The idle rules are checked over the thirty cycles that follow. Grant changes only on falling edges, so each rising edge sees a stable window for the abort-and-redo path.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic [3:0] {
    ST_INIT,
    ST_SEED,
    ST_SETUP,
    ST_RD,
    ST_CAP,
    ST_WR,
    ST_IDLE,
    ST_SC_RD,
    ST_SC_WR
  } ca_state_e;
endpackage

// File: rtl/ca_rst_sync.sv
module ca_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh <= '0;
    else           sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh[STAGES-1];
endmodule

// File: rtl/ca_lfsr.sv
module ca_lfsr #(
  parameter int          W    = 31,
  parameter logic [W-1:0] SEED = 31'h5555_5555
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = state;
    if (adv) nxt = {state[W-2:0], state[W-4] ^ state[W-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= nxt;
  end
endmodule

// File: rtl/ca_nbr_addr.sv
module ca_nbr_addr #(
  parameter int COLS     = 320,
  parameter int LAST_COL = 313,
  parameter int AW       = 17,
  parameter int XW       = 9,
  parameter int YW       = 8
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic [1:0]    k,
  output logic [AW-1:0] addr,
  output logic          in_range
);
  logic [XW:0]   cx;
  logic [XW:0]   col;
  logic [YW-1:0] row;

  always_comb begin
    cx       = {1'b0, x} + (XW+1)'(k);
    col      = cx - (XW+1)'(1);
    row      = y - YW'(1);
    in_range = (cx != '0) && (col <= (XW+1)'(LAST_COL));
    addr     = AW'(row) * AW'(COLS) + AW'(col);
  end
endmodule

// File: rtl/ca_pixel_fmt.sv
module ca_pixel_fmt #(
  parameter int WORD_W = 16,
  parameter int RW     = 31
) (
  input  logic              live,
  input  logic [RW-1:0]     rnd,
  output logic [WORD_W-1:0] word
);
  localparam int FW     = (WORD_W - 1) / 3;
  localparam int STRIDE = 7;

  logic [WORD_W-1:0] colour;

  always_comb begin
    colour = '0;
    colour[WORD_W-1] = 1'b1;
    for (int i = 0; i < 3; i++) begin
      colour[i*FW + FW-1] = 1'b1;
      for (int b = 0; b < FW-1; b++) colour[i*FW + b] = rnd[i*STRIDE + b];
    end
    word = live ? colour : '0;
  end
endmodule

// File: rtl/ca_row_gen.sv
module ca_row_gen
  import ca_pkg::*;
#(
  parameter int COLS     = 320,
  parameter int ROWS     = 240,
  parameter int LAST_COL = 313,
  parameter int LAST_ROW = 230,
  parameter int WORD_W   = 16,
  parameter int LFSR_W   = 31,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 31'h5555_5555,
  localparam int AW = $clog2(COLS*ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seed_rand,
  input  logic              scroll,
  input  logic [7:0]        rule,
  input  logic              grant,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              idle
);
  localparam int XW     = $clog2(COLS);
  localparam int YW     = $clog2(ROWS);
  localparam int ALIVE  = WORD_W - 1;
  localparam int CENTER = (LAST_COL + 1) / 2;

  ca_state_e         st, st_n;
  logic [XW-1:0]     x, x_n;
  logic [YW-1:0]     y, y_n;
  logic [1:0]        k, k_n;
  logic [2:0]        pat, pat_n;
  logic              lock, lock_n;
  logic              mode, mode_n;

  logic              rst_n_s;
  logic [LFSR_W-1:0] rnd;
  logic              rnd_adv;
  logic [AW-1:0]     nb_addr;
  logic              nb_in;
  logic              px_live;
  logic [WORD_W-1:0] px_word;
  logic              req_c, we_c;
  logic              last_x;

  function automatic logic [AW-1:0] pix(input logic [YW-1:0] r, input logic [XW-1:0] c);
    return AW'(r) * AW'(COLS) + AW'(c);
  endfunction

  ca_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  ca_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .adv   (rnd_adv),
    .state (rnd)
  );

  ca_nbr_addr #(.COLS(COLS), .LAST_COL(LAST_COL), .AW(AW), .XW(XW), .YW(YW)) u_nbr (
    .x        (x),
    .y        (y),
    .k        (k),
    .addr     (nb_addr),
    .in_range (nb_in)
  );

  ca_pixel_fmt #(.WORD_W(WORD_W), .RW(LFSR_W)) u_fmt (
    .live (px_live),
    .rnd  (rnd),
    .word (px_word)
  );

  assign last_x  = (x == XW'(LAST_COL));
  assign px_live = (st == ST_SEED) ? rnd[LFSR_W-1] : rule[pat];

  // next-state logic
  always_comb begin
    st_n   = st;
    x_n    = x;
    y_n    = y;
    k_n    = k;
    pat_n  = pat;
    lock_n = lock;
    mode_n = mode;
    case (st)
      ST_INIT, ST_IDLE: begin
        if (start) begin
          mode_n = seed_rand;
          x_n    = '0;
          y_n    = '0;
          st_n   = ST_SEED;
        end else if (scroll && st == ST_IDLE) begin
          x_n  = '0;
          st_n = ST_SC_RD;
        end
      end
      ST_SEED: begin
        if (grant) begin
          if (last_x) begin
            x_n  = '0;
            y_n  = YW'(1);
            st_n = ST_SETUP;
          end else begin
            x_n = x + XW'(1);
          end
        end
      end
      ST_SETUP: begin
        lock_n = 1'b0;
        pat_n  = '0;
        k_n    = '0;
        st_n   = ST_RD;
      end
      ST_RD: begin
        if (!grant) lock_n = 1'b1;
        else        st_n   = ST_CAP;
      end
      ST_CAP: begin
        if (!grant) lock_n = 1'b1;
        pat_n = {pat[1:0], nb_in & mem_rdata[ALIVE]};
        if (k == 2'd2) begin
          st_n = ST_WR;
        end else begin
          k_n  = k + 2'd1;
          st_n = ST_RD;
        end
      end
      ST_WR: begin
        st_n = ST_SETUP;
        if (grant && !lock) begin
          if (last_x) begin
            x_n = '0;
            if (y == YW'(LAST_ROW)) st_n = ST_IDLE;
            else                    y_n  = y + YW'(1);
          end else begin
            x_n = x + XW'(1);
          end
        end
      end
      ST_SC_RD: begin
        if (grant) st_n = ST_SC_WR;
      end
      ST_SC_WR: begin
        st_n = ST_SC_RD;
        if (grant) begin
          if (last_x) begin
            x_n  = '0;
            y_n  = YW'(1);
            st_n = ST_SETUP;
          end else begin
            x_n = x + XW'(1);
          end
        end
      end
      default: st_n = ST_INIT;
    endcase
  end

  // memory port
  always_comb begin
    req_c     = 1'b0;
    we_c      = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      ST_SEED: begin
        req_c    = 1'b1;
        we_c     = 1'b1;
        mem_addr = pix('0, x);
        if (mode)        mem_wdata = px_word;
        else if (x == XW'(CENTER)) mem_wdata = '1;
      end
      ST_RD: begin
        req_c    = nb_in;
        mem_addr = nb_addr;
      end
      ST_WR: begin
        req_c     = !lock;
        we_c      = 1'b1;
        mem_addr  = pix(y, x);
        mem_wdata = px_word;
      end
      ST_SC_RD: begin
        req_c    = 1'b1;
        mem_addr = pix(YW'(LAST_ROW), x);
      end
      ST_SC_WR: begin
        req_c     = 1'b1;
        we_c      = 1'b1;
        mem_addr  = pix('0, x);
        mem_wdata = mem_rdata;
      end
      default: ;
    endcase
  end

  assign mem_req = req_c & grant;
  assign mem_we  = mem_req & we_c;
  assign idle    = (st == ST_IDLE);
  assign rnd_adv = grant && (((st == ST_SEED) && mode) ||
                             ((st == ST_WR) && !lock && rule[pat]));

  // state registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st   <= ST_INIT;
      x    <= '0;
      y    <= '0;
      k    <= '0;
      pat  <= '0;
      lock <= 1'b0;
      mode <= 1'b0;
    end else begin
      st   <= st_n;
      x    <= x_n;
      y    <= y_n;
      k    <= k_n;
      pat  <= pat_n;
      lock <= lock_n;
      mode <= mode_n;
    end
  end
endmodule

// File: rtl/ca_row_gen_chk.sv
module ca_row_gen_chk #(
  parameter int COLS     = 320,
  parameter int ROWS     = 240,
  parameter int LAST_COL = 313,
  parameter int AW       = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          scroll,
  input logic          grant,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          idle
);
  p_req_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> grant);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_req);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start && !scroll) |=> idle);

  p_start_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start) |=> !idle);

  p_col_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ((int'(mem_addr) % COLS) <= LAST_COL));

  p_addr_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(mem_addr) < COLS*ROWS));
endmodule

bind ca_row_gen ca_row_gen_chk #(
  .COLS(COLS), .ROWS(ROWS), .LAST_COL(LAST_COL), .AW(AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .scroll   (scroll),
  .grant    (grant),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .idle     (idle)
);

// File: tb/sim_ca_row_gen.sv
`timescale 1ns/1ps
module sim_ca_row_gen;
  localparam int BC  = 16;
  localparam int BR  = 10;
  localparam int BLC = 11;
  localparam int BLR = 7;
  localparam int CEN = (BLC + 1) / 2;
  localparam int AW  = $clog2(BC*BR);
  localparam int CELLS = (BLR + 1) * (BLC + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          seed_rand = 1'b0;
  logic          scroll = 1'b0;
  logic [7:0]    rule = 8'd0;
  logic          grant = 1'b1;
  logic [15:0]   mem_rdata = 16'h0;
  logic          mem_req, mem_we, idle;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;

  ca_row_gen #(.COLS(BC), .ROWS(BR), .LAST_COL(BLC), .LAST_ROW(BLR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_rand(seed_rand),
    .scroll(scroll), .rule(rule), .grant(grant), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .idle(idle)
  );

  // frame buffer model and write monitor
  logic [15:0] mem [BC*BR];
  int   wcnt = 0, wbad = 0, rbad = 0, reqcnt = 0, wr_r = 0, wr_c = 0;
  logic mon_clr = 1'b0, junk_go = 1'b0, pre_go = 1'b0;

  always @(posedge clk) begin
    if (pre_go)
      for (int i = 0; i < BC*BR; i++) mem[i] <= ((i % BC) > BLC) ? 16'h8000 : 16'h0000;
    if (junk_go)
      for (int c = 0; c <= BLC; c++)
        if (!mem[BLR*BC+c][15]) mem[BLR*BC+c] <= 16'h7FFF;
    if (mon_clr) begin
      wcnt <= 0; wbad <= 0; rbad <= 0; wr_r <= 0; wr_c <= 0;
    end else begin
      if (mem_req) reqcnt <= reqcnt + 1;
      if (mem_req && mem_we) begin
        mem[int'(mem_addr)] <= mem_wdata;
        wcnt <= wcnt + 1;
        if (int'(mem_addr) != wr_r*BC + wr_c) wbad <= wbad + 1;
        if (wr_c == BLC) begin wr_c <= 0; wr_r <= wr_r + 1; end
        else wr_c <= wr_c + 1;
      end
      if (mem_req && !mem_we) begin
        mem_rdata <= mem[int'(mem_addr)];
        if ((int'(mem_addr) % BC) > BLC) rbad <= rbad + 1;
      end
    end
  end

  // grant: always on, or random windows
  bit gmode = 1'b0, gon = 1'b1;
  int gcnt = 0;
  always @(negedge clk) begin
    if (!gmode) grant = 1'b1;
    else if (gcnt == 0) begin
      gon  = !gon;
      gcnt = gon ? int'($urandom_range(20, 4)) : int'($urandom_range(6, 1));
      grant = gon;
    end else gcnt = gcnt - 1;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // bench reference model
  logic [30:0] blf = 31'h5555_5555;
  bit          ex [BR][BC];
  logic [15:0] seedw [BC];

  function automatic logic [30:0] lf_step(input logic [30:0] g);
    return {g[29:0], g[27] ^ g[30]};
  endfunction

  function automatic logic [15:0] lf_word(input logic [30:0] g);
    return {1'b1, 1'b1, g[17:14], 1'b1, g[10:7], 1'b1, g[3:0]};
  endfunction

  task automatic predict(input logic [7:0] r);
    for (int y = 1; y <= BLR; y++)
      for (int c = 0; c <= BLC; c++) begin
        bit l, m, rr;
        l  = (c > 0)   ? ex[y-1][c-1] : 1'b0;
        m  = ex[y-1][c];
        rr = (c < BLC) ? ex[y-1][c+1] : 1'b0;
        ex[y][c] = r[{l, m, rr}];
        if (ex[y][c]) blf = lf_step(blf);
      end
  endtask

  task automatic run_frame(input logic [7:0] r, input bit rnd, input bit scr, input bit choppy);
    int t;
    int snap;
    gmode = choppy;
    rule  = r;
    for (int c = 0; c <= BLC; c++) begin
      if (scr) begin
        seedw[c] = mem[BLR*BC+c];
        ex[0][c] = seedw[c][15];
      end else if (rnd) begin
        ex[0][c] = blf[30];
        seedw[c] = blf[30] ? lf_word(blf) : 16'h0000;
        blf = lf_step(blf);
      end else begin
        ex[0][c] = (c == CEN);
        seedw[c] = (c == CEN) ? 16'hFFFF : 16'h0000;
      end
    end
    predict(r);
    @(negedge clk);
    mon_clr = 1'b1;
    if (scr) scroll = 1'b1;
    else begin start = 1'b1; seed_rand = rnd; end
    @(negedge clk);
    mon_clr = 1'b0; start = 1'b0; scroll = 1'b0;
    t = 0;
    while (!idle && t < 40000) begin @(negedge clk); t++; end
    chk(idle, $sformatf("R8 idle after pass rule %0d", r), idle, 1);
    chk(wcnt == CELLS && wbad == 0, "R7 R8 each cell written once in order",
        wcnt*1000 + wbad, CELLS*1000);
    chk(rbad == 0, "R3 no read beyond last column", rbad, 0);
    begin
      bit ok0 = 1'b1;
      longint a0 = 0, e0 = 0;
      for (int c = 0; c <= BLC; c++)
        if (mem[c] != seedw[c]) begin ok0 = 1'b0; a0 = mem[c]; e0 = seedw[c]; end
      chk(ok0, scr ? "R10 top row copied" : (rnd ? "R5 R12 random seed row" : "R4 centre seed row"),
          a0, e0);
    end
    for (int y = 1; y <= BLR; y++) begin
      bit okf = 1'b1;
      longint am = 0, em = 0;
      for (int c = 0; c <= BLC; c++) begin
        logic [15:0] w = mem[y*BC+c];
        am |= longint'(w[15]) << c;
        em |= longint'(ex[y][c]) << c;
        if (ex[y][c] ? !(w[15] && w[14] && w[9] && w[4]) : (w != 16'h0)) okf = 1'b0;
      end
      chk(okf && am == em, $sformatf("R1 R2 row %0d rule %0d", y, r), am, em);
    end
    snap = reqcnt;
    repeat (30) @(negedge clk);
    chk(idle && reqcnt == snap, "R9 idle holds without requests",
        reqcnt - snap, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    pre_go = 1'b1;
    repeat (4) @(negedge clk);
    pre_go = 1'b0;
    rst_n  = 1'b1;
    repeat (20) @(negedge clk);
    chk(!idle && !mem_req && reqcnt == 0, "R11 reset state waits for start",
        {idle, mem_req, reqcnt[7:0]}, 0);

    run_frame(8'd90,  1'b0, 1'b0, 1'b0);
    run_frame(8'd30,  1'b0, 1'b0, 1'b1);
    run_frame(8'd14,  1'b0, 1'b0, 1'b1);   // R3 edge rule
    run_frame(8'd110, 1'b1, 1'b0, 1'b1);
    @(negedge clk); junk_go = 1'b1;        // R2 colour-only words
    @(negedge clk); junk_go = 1'b0;
    run_frame(8'd30,  1'b0, 1'b1, 1'b1);   // R10 scroll
    run_frame(8'd0,   1'b1, 1'b0, 1'b0);
    run_frame(8'd255, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++)
      run_frame(8'($urandom_range(255, 0)), 1'b1, 1'b0, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule